// File: doc/BRIEF.md
# Watchdog Timer with Shared Prescaler

This block is a watchdog counter clocked from its own free-running timebase, which keeps running while the main processor clock is stopped in sleep. A base period of `BASE_TICKS` timebase ticks can be stretched by a prescaler. Software can hand the prescaler to the watchdog and pick a power-of-two ratio from 1:1 to 1:128.

Software restarts the count with a clear strobe. Entering sleep restarts it the same way, so a sleeping device gets the full period before it wakes. When the count runs out, the block issues a one-tick pulse. While the device is awake the pulse is a device reset; while it is asleep the pulse is a wake-up reset. A status flag drops when a time-out occurs and is raised again by power-on, by a clear or by sleep entry. A configuration enable bit of 0 disables the watchdog entirely.

All inputs are assumed to be synchronous to the timebase clock. Instruction decoding and oscillator accuracy are handled outside the block.

Top module: `wdog_core`

## Requirements
- R1: With the watchdog enabled and the prescaler not assigned to it, a time-out pulse appears exactly `BASE_TICKS` ticks after the tick on which the count was last restarted.
- R2: With the prescaler assigned (`pre_to_wdt_i`=1), a ratio field value n (0 to 7) makes the period `BASE_TICKS`·2^n ticks.
- R3: With the prescaler not assigned, the ratio field has no effect and the period is `BASE_TICKS`.
- R4: A clear strobe restarts both the counter and the prescaler. A clear on the same tick as a would-be expiry suppresses that pulse.
- R5: A sleep-entry strobe restarts the count exactly as a clear does, including suppression of a coincident expiry.
- R6: A time-out with `asleep_i`=1 gives `wake_rst_o` and leaves `dev_rst_o` low. A time-out with `asleep_i`=0 gives `dev_rst_o` and leaves `wake_rst_o` low.
- R7: Each pulse lasts exactly one tick. The count restarts from zero on that tick, so the next pulse follows one full period later.
- R8: `timeout_flag_o` is 1 after reset. It goes to 0 on the tick a pulse appears, and returns to 1 on the tick after a clear or sleep-entry strobe.
- R9: While `wdt_en_i`=0, no pulse is issued and the count is held at zero. After the watchdog is enabled again, a full period elapses before the first pulse.
- R10: During reset both pulse outputs are 0 and `timeout_flag_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog timebase clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| wdt_en_i | input | 1 | Configuration enable; 0 disables the watchdog |
| clr_i | input | 1 | Clear-watchdog strobe, one tick |
| sleep_enter_i | input | 1 | Sleep-entry strobe, one tick |
| asleep_i | input | 1 | Device is in sleep |
| pre_to_wdt_i | input | 1 | 1 = prescaler assigned to the watchdog |
| ratio_i | input | RATIO_W | Prescaler ratio exponent, divide by 2^n |
| dev_rst_o | output | 1 | Device-reset pulse on a time-out while awake |
| wake_rst_o | output | 1 | Wake-up-reset pulse on a time-out while asleep |
| timeout_flag_o | output | 1 | Time-out status; 0 after a watchdog time-out |

## Verification
A restart strobe (clear or sleep entry) and the expiry can fall on the same tick. The bench provokes this by waiting exactly one period minus one tick after a restart and then strobing. The other overlap is a pulse landing while `asleep_i` changes. The bench judges both with a per-tick reference model: a restart must win, giving no pulse and a raised flag, and the kind of pulse must follow the sleep state sampled on the expiry tick.

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int BASE_TICKS = 16,
  parameter int RATIO_W    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wdt_en_i,
  input  logic               clr_i,
  input  logic               sleep_enter_i,
  input  logic               asleep_i,
  input  logic               pre_to_wdt_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               dev_rst_o,
  output logic               wake_rst_o,
  output logic               timeout_flag_o
);
  localparam int PRE_W = (1 << RATIO_W) - 1;
  localparam int CNT_W = (BASE_TICKS > 1) ? $clog2(BASE_TICKS) : 1;

  logic [PRE_W-1:0] pre_q, pre_mask;
  logic [CNT_W-1:0] cnt_q;
  logic restart, pre_tick, expire;

  assign restart  = clr_i | sleep_enter_i;
  assign pre_mask = pre_to_wdt_i ? ~({PRE_W{1'b1}} << ratio_i) : '0;
  assign pre_tick = (pre_q & pre_mask) == pre_mask;
  assign expire   = wdt_en_i && !restart && pre_tick && (cnt_q == CNT_W'(BASE_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (!wdt_en_i || restart || expire) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (pre_tick) begin
      pre_q <= '0;
      cnt_q <= cnt_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_rst_o      <= 1'b0;
      wake_rst_o     <= 1'b0;
      timeout_flag_o <= 1'b1;
    end else begin
      dev_rst_o  <= expire & ~asleep_i;
      wake_rst_o <= expire & asleep_i;
      if (restart)     timeout_flag_o <= 1'b1;
      else if (expire) timeout_flag_o <= 1'b0;
    end
  end

  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_rst_o && wake_rst_o)); // R6
  AST_WAKE_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_rst_o && !wake_rst_o && asleep_i) |=> !dev_rst_o); // R6
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rst_o || wake_rst_o) |=> !(dev_rst_o || wake_rst_o)); // R7
  AST_RESTART_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i || sleep_enter_i) |=> (!dev_rst_o && !wake_rst_o && timeout_flag_o)); // R4
  AST_FLAG_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rst_o || wake_rst_o) |-> !timeout_flag_o); // R8
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_en_i |=> !(dev_rst_o || wake_rst_o)); // R9
endmodule

// File: tb/test_wdog_core.sv
module test_wdog_core;
  localparam int BASE = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, clr = 1'b0, slp = 1'b0, asleep = 1'b0, psa = 1'b0;
  logic [2:0] ratio = 3'd0;
  logic dev, wake, flag;
  int checks = 0, errors = 0, cycles = 0;
  int t = 0;
  bit e_dev = 0, e_wake = 0, e_flag = 1;
  string phase = "R10 reset";

  always #10 clk = ~clk;

  wdog_core #(.BASE_TICKS(BASE), .RATIO_W(3)) i_wdog_core (
    .clk(clk), .rst_n(rst_n), .wdt_en_i(en), .clr_i(clr), .sleep_enter_i(slp),
    .asleep_i(asleep), .pre_to_wdt_i(psa), .ratio_i(ratio),
    .dev_rst_o(dev), .wake_rst_o(wake), .timeout_flag_o(flag));

  function automatic int period();
    return BASE * (psa ? (1 << ratio) : 1);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      t = 0; e_dev = 0; e_wake = 0; e_flag = 1;
    end else begin
      e_dev = 0; e_wake = 0;
      if (clr || slp) begin t = 0; e_flag = 1; end
      else if (!en) t = 0;
      else begin
        t++;
        if (t == period()) begin
          t = 0; e_flag = 0;
          if (asleep) e_wake = 1; else e_dev = 1;
        end
      end
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic cmp(string what, logic act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at cycle %0d", phase, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cmp("dev_rst_o (R6)", dev, e_dev);
    cmp("wake_rst_o (R6)", wake, e_wake);
    cmp("timeout_flag_o (R8)", flag, e_flag);
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe_clr();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic strobe_slp();
    @(negedge clk) slp = 1'b1;
    @(negedge clk) slp = 1'b0;
  endtask

  initial begin
    step(3);
    phase = "R1 R7 R8 base period awake";
    @(negedge clk) rst_n = 1'b1; en = 1'b1;
    step(3 * BASE + 2);

    phase = "R3 ratio ignored when unassigned";
    @(negedge clk) ratio = 3'd7;
    strobe_clr();
    step(3 * BASE + 1);

    for (int n = 0; n < 8; n++) begin
      phase = $sformatf("R2 ratio %0d", n);
      @(negedge clk) psa = 1'b1; ratio = 3'(n);
      strobe_clr();
      step(2 * BASE * (1 << n) + 3);
    end

    phase = "R4 clear at expiry tick";
    @(negedge clk) ratio = 3'd2;
    strobe_clr();
    step(BASE * 4 - 2);
    strobe_clr();
    step(BASE * 2);
    strobe_clr();
    step(BASE * 4 + 4);

    phase = "R5 R6 sleep entry at expiry then wake pulses";
    strobe_clr();
    step(BASE * 4 - 2);
    @(negedge clk) slp = 1'b1;
    @(negedge clk) slp = 1'b0; asleep = 1'b1;
    step(BASE * 8 + 3);
    @(negedge clk) asleep = 1'b0;
    strobe_slp();
    step(BASE * 4 + 2);

    phase = "R9 disabled then re-enabled";
    @(negedge clk) en = 1'b0;
    step(BASE * 20);
    @(negedge clk) en = 1'b1;
    step(BASE * 8 + 3);

    phase = "R9 R8 clear while disabled";
    @(negedge clk) en = 1'b0;
    strobe_clr();
    step(50);
    @(negedge clk) en = 1'b1; psa = 1'b0;
    step(BASE * 2 + 2);

    phase = "R10 reset again";
    @(negedge clk) rst_n = 1'b0;
    step(3);
    cmp("R10 dev_rst_o in reset", dev, 1'b0);
    cmp("R10 timeout_flag_o in reset", flag, 1'b1);
    step(1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule